// File: doc/BRIEF.md
# Ping-Pong Endpoint Buffer Controller

This block manages the buffer ownership of one user endpoint that has two equally sized data buffers used in turn. The direction of an endpoint is fixed by its configuration. On a receive endpoint (data from the host) the transaction engine fills one buffer while firmware empties the other. On a transmit endpoint (data to the host) firmware fills one buffer while the engine sends the other. The block holds a ready flag and a byte count for each buffer. It tracks which buffer the engine must use next, and it answers each engine request with a grant, a flow-control refusal or a silent drop.

Firmware uses a register-style port to write the endpoint configuration (direction, transfer type, buffer size) and to hand a buffer to the engine by marking it ready. The flags and counts of both buffers can be read at all times. The engine raises a request at the start of a transaction and receives a registered response. When the transaction ends it reports success or failure, and on a receive endpoint it also reports the number of bytes that arrived. The block stores no data and does no packet framing.

Top module: `pp_ep_ctrl`

## Requirements
- R1: After reset both ready flags are 0, both counts are 0, the next-buffer index is 0, the effective size is 0, no response is pending, and the endpoint is receive-direction bulk.
- R2: A configuration write sets the effective size to the requested size, clamped to the limit of the transfer type. Type codes are 0 = bulk (limit 512), 1 = interrupt (limit 64), 2 = isochronous (limit 1024), and code 3 is handled as bulk.
- R3: A configuration write clears both ready flags and both counts, sets the next-buffer index to 0 and abandons any granted transaction. It takes priority over every other input in the same cycle.
- R4: A ready write sets the ready flag of the selected buffer. On a transmit endpoint the count becomes min(written count, effective size). On a receive endpoint the count becomes 0.
- R5: When a request arrives while idle and the next buffer is ready, a response is presented in the following cycle only. The response has code 1 (grant), buffer index = next buffer, and transmit count = that buffer's count on a transmit endpoint or 0 on a receive endpoint.
- R6: When a request arrives while idle and the next buffer is not ready, the response is code 2 (refuse) for bulk and interrupt, or code 3 (drop) for isochronous. Flags, counts and the next index do not change.
- R7: A successful completion of a granted transaction clears that buffer's ready flag and toggles the next-buffer index. On a receive endpoint the count becomes min(received length, effective size). On a transmit endpoint the count is kept.
- R8: A failed completion leaves the granted buffer ready and the next-buffer index unchanged, so the retry uses the same buffer.
- R9: A series of successful transactions uses buffer 0, 1, 0, 1 in turn.
- R10: While a transaction is granted, further requests get no response, and a ready write to the granted buffer is ignored. A completion that arrives while no transaction is granted is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_dir_in | input | 1 | 1 = transmit (to host), 0 = receive (from host) |
| cfg_type | input | 2 | Transfer type code |
| cfg_size | input | CNT_W | Requested buffer size in bytes |
| rdy_we | input | 1 | Ready write strobe |
| rdy_sel | input | 1 | Buffer selected by the ready write |
| rdy_cnt | input | CNT_W | Byte count for a transmit buffer |
| eng_req | input | 1 | Engine transaction request |
| eng_done | input | 1 | Engine transaction completion |
| eng_ok | input | 1 | Completion was error free |
| eng_len | input | CNT_W | Bytes received on a receive transaction |
| eng_rsp_vld | output | 1 | Response valid (one cycle) |
| eng_rsp | output | 2 | Response code: 1 grant, 2 refuse, 3 drop |
| eng_buf | output | 1 | Buffer index of the response |
| eng_tx_cnt | output | CNT_W | Bytes to send on a granted transmit |
| buf_rdy | output | 2 | Ready flag per buffer |
| buf_cnt | output | 2*CNT_W | Counts, buffer 0 in the low bits |
| ep_next | output | 1 | Buffer the engine uses next |
| ep_size | output | CNT_W | Effective (clamped) buffer size |

## Verification
The bench builds the block with the default limits of 512, 64 and 1024 bytes, which gives an 11-bit count. With this width, requests above every limit (600, 100, 2000) can be written, so clamping is reached for each type and for the spare type code. The same width allows received lengths that exceed a configured size, so the receive-count clamp is exercised. Small sizes such as 200 bytes on an isochronous endpoint show that the limit and the user size are applied separately.

// File: rtl/pp_ep_pkg.sv
package pp_ep_pkg;
    typedef enum logic [1:0] {
        XT_BULK = 2'd0,
        XT_INTR = 2'd1,
        XT_ISO  = 2'd2,
        XT_RSVD = 2'd3
    } xfer_t;

    typedef enum logic [1:0] {
        RSP_NONE  = 2'd0,
        RSP_GRANT = 2'd1,
        RSP_NAK   = 2'd2,
        RSP_DROP  = 2'd3
    } rsp_t;
endpackage

// File: rtl/pp_ep_limit.sv
module pp_ep_limit
    import pp_ep_pkg::*;
#(
    parameter int BULK_MAX = 512,
    parameter int INTR_MAX = 64,
    parameter int ISO_MAX  = 1024,
    parameter int CNT_W    = 11
) (
    input  xfer_t              typ,
    input  logic [CNT_W-1:0]   req,
    output logic [CNT_W-1:0]   eff
);
    localparam logic [CNT_W-1:0] LIM_BULK = CNT_W'(BULK_MAX);
    localparam logic [CNT_W-1:0] LIM_INTR = CNT_W'(INTR_MAX);
    localparam logic [CNT_W-1:0] LIM_ISO  = CNT_W'(ISO_MAX);

    logic [CNT_W-1:0] lim;

    always_comb begin
        unique case (typ)
            XT_INTR: lim = LIM_INTR;
            XT_ISO:  lim = LIM_ISO;
            default: lim = LIM_BULK;
        endcase
        eff = (req > lim) ? lim : req;
    end
endmodule

// File: rtl/pp_ep_slot.sv
module pp_ep_slot #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             take,
    input  logic [CNT_W-1:0] take_cnt,
    input  logic             set,
    input  logic [CNT_W-1:0] set_cnt,
    output logic             rdy,
    output logic [CNT_W-1:0] cnt
);
    typedef struct packed {
        logic             rdy;
        logic [CNT_W-1:0] cnt;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (clr) begin
            slot_d.rdy = 1'b0;
            slot_d.cnt = '0;
        end else if (take) begin
            slot_d.rdy = 1'b0;
            slot_d.cnt = take_cnt;
        end else if (set) begin
            slot_d.rdy = 1'b1;
            slot_d.cnt = set_cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign rdy = slot_q.rdy;
    assign cnt = slot_q.cnt;
endmodule

// File: rtl/pp_ep_ctrl.sv
module pp_ep_ctrl
    import pp_ep_pkg::*;
#(
    parameter int BULK_MAX = 512,
    parameter int INTR_MAX = 64,
    parameter int ISO_MAX  = 1024,
    parameter int CNT_W    = $clog2(ISO_MAX + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic               cfg_dir_in,
    input  logic [1:0]         cfg_type,
    input  logic [CNT_W-1:0]   cfg_size,
    input  logic               rdy_we,
    input  logic               rdy_sel,
    input  logic [CNT_W-1:0]   rdy_cnt,
    input  logic               eng_req,
    input  logic               eng_done,
    input  logic               eng_ok,
    input  logic [CNT_W-1:0]   eng_len,
    output logic               eng_rsp_vld,
    output logic [1:0]         eng_rsp,
    output logic               eng_buf,
    output logic [CNT_W-1:0]   eng_tx_cnt,
    output logic [1:0]         buf_rdy,
    output logic [2*CNT_W-1:0] buf_cnt,
    output logic               ep_next,
    output logic [CNT_W-1:0]   ep_size
);
    localparam int NBUF = 2;

    typedef struct packed {
        logic             dir_in;
        xfer_t            typ;
        logic [CNT_W-1:0] size;
        logic             nxt;
        logic             busy;
        logic             gbuf;
        logic             rsp_vld;
        rsp_t             rsp;
        logic             rbuf;
        logic [CNT_W-1:0] txcnt;
    } ctl_t;

    ctl_t st_d, st_q;

    logic [CNT_W-1:0] cfg_eff;
    logic [NBUF-1:0]  s_clr, s_take, s_set, s_rdy;
    logic [CNT_W-1:0] s_take_cnt, s_set_cnt;
    logic [CNT_W-1:0] s_cnt [NBUF];

    pp_ep_limit #(
        .BULK_MAX (BULK_MAX),
        .INTR_MAX (INTR_MAX),
        .ISO_MAX  (ISO_MAX),
        .CNT_W    (CNT_W)
    ) u_limit (
        .typ (xfer_t'(cfg_type)),
        .req (cfg_size),
        .eff (cfg_eff)
    );

    for (genvar b = 0; b < NBUF; b++) begin : g_slot
        pp_ep_slot #(.CNT_W(CNT_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (s_clr[b]),
            .take     (s_take[b]),
            .take_cnt (s_take_cnt),
            .set      (s_set[b]),
            .set_cnt  (s_set_cnt),
            .rdy      (s_rdy[b]),
            .cnt      (s_cnt[b])
        );
        assign buf_cnt[b*CNT_W +: CNT_W] = s_cnt[b];
    end

    always_comb begin
        st_d         = st_q;
        st_d.rsp_vld = 1'b0;
        st_d.rsp     = RSP_NONE;
        s_clr        = '0;
        s_take       = '0;
        s_set        = '0;
        s_take_cnt   = '0;
        s_set_cnt    = '0;

        if (cfg_we) begin
            st_d.dir_in = cfg_dir_in;
            st_d.typ    = xfer_t'(cfg_type);
            st_d.size   = cfg_eff;
            st_d.nxt    = 1'b0;
            st_d.busy   = 1'b0;
            st_d.gbuf   = 1'b0;
            s_clr       = '1;
        end else begin
            // engine side: completion when busy, request when idle
            if (st_q.busy) begin
                if (eng_done) begin
                    st_d.busy = 1'b0;
                    if (eng_ok) begin
                        s_take[st_q.gbuf] = 1'b1;
                        if (st_q.dir_in)
                            s_take_cnt = s_cnt[st_q.gbuf];
                        else
                            s_take_cnt = (eng_len > st_q.size) ? st_q.size : eng_len;
                        st_d.nxt = ~st_q.gbuf;
                    end
                end
            end else if (eng_req) begin
                st_d.rsp_vld = 1'b1;
                st_d.rbuf    = st_q.nxt;
                st_d.txcnt   = '0;
                if (s_rdy[st_q.nxt]) begin
                    st_d.rsp  = RSP_GRANT;
                    st_d.busy = 1'b1;
                    st_d.gbuf = st_q.nxt;
                    if (st_q.dir_in) st_d.txcnt = s_cnt[st_q.nxt];
                end else if (st_q.typ == XT_ISO) begin
                    st_d.rsp = RSP_DROP;
                end else begin
                    st_d.rsp = RSP_NAK;
                end
            end

            // firmware side: hand a buffer to the engine
            if (rdy_we && !(st_q.busy && (rdy_sel == st_q.gbuf))) begin
                s_set[rdy_sel] = 1'b1;
                if (st_q.dir_in)
                    s_set_cnt = (rdy_cnt > st_q.size) ? st_q.size : rdy_cnt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign eng_rsp_vld = st_q.rsp_vld;
    assign eng_rsp     = st_q.rsp;
    assign eng_buf     = st_q.rbuf;
    assign eng_tx_cnt  = st_q.txcnt;
    assign buf_rdy     = s_rdy;
    assign ep_next     = st_q.nxt;
    assign ep_size     = st_q.size;

    logic  busy_w;
    xfer_t typ_w;
    assign busy_w = st_q.busy;
    assign typ_w  = st_q.typ;
endmodule

// File: rtl/pp_ep_chk.sv
module pp_ep_chk
    import pp_ep_pkg::*;
#(
    parameter int ISO_MAX = 1024,
    parameter int CNT_W   = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic             eng_req,
    input logic             eng_done,
    input logic             eng_ok,
    input logic             eng_rsp_vld,
    input logic [1:0]       eng_rsp,
    input logic             ep_next,
    input logic [CNT_W-1:0] ep_size,
    input logic             busy,
    input xfer_t            typ
);
    localparam logic [CNT_W-1:0] SZ_TOP = CNT_W'(ISO_MAX);

    // R2
    size_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ep_size <= SZ_TOP);

    // R5
    rsp_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_rsp_vld |-> $past(eng_req));

    // R10
    grant_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rsp_vld && eng_rsp == RSP_GRANT) |-> busy);

    // R6
    drop_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rsp_vld && eng_rsp == RSP_DROP) |-> typ == XT_ISO);

    // R7
    next_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && eng_done && eng_ok && !cfg_we) |=> ep_next != $past(ep_next));

    // R8
    next_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && eng_done && !eng_ok && !cfg_we) |=> $stable(ep_next));
endmodule

bind pp_ep_ctrl pp_ep_chk #(.ISO_MAX(ISO_MAX), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .eng_req     (eng_req),
    .eng_done    (eng_done),
    .eng_ok      (eng_ok),
    .eng_rsp_vld (eng_rsp_vld),
    .eng_rsp     (eng_rsp),
    .ep_next     (ep_next),
    .ep_size     (ep_size),
    .busy        (busy_w),
    .typ         (typ_w)
);

// File: tb/pp_ep_ctrl_test.sv
module pp_ep_ctrl_test;
    localparam int CW = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 0, cfg_dir_in = 0;
    logic [1:0] cfg_type = 0;
    logic [CW-1:0] cfg_size = 0;
    logic rdy_we = 0, rdy_sel = 0;
    logic [CW-1:0] rdy_cnt = 0;
    logic eng_req = 0, eng_done = 0, eng_ok = 0;
    logic [CW-1:0] eng_len = 0;
    logic eng_rsp_vld, eng_buf, ep_next;
    logic [1:0] eng_rsp, buf_rdy;
    logic [CW-1:0] eng_tx_cnt, ep_size;
    logic [2*CW-1:0] buf_cnt;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    pp_ep_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_dir_in(cfg_dir_in), .cfg_type(cfg_type), .cfg_size(cfg_size),
        .rdy_we(rdy_we), .rdy_sel(rdy_sel), .rdy_cnt(rdy_cnt),
        .eng_req(eng_req), .eng_done(eng_done), .eng_ok(eng_ok), .eng_len(eng_len),
        .eng_rsp_vld(eng_rsp_vld), .eng_rsp(eng_rsp), .eng_buf(eng_buf), .eng_tx_cnt(eng_tx_cnt),
        .buf_rdy(buf_rdy), .buf_cnt(buf_cnt), .ep_next(ep_next), .ep_size(ep_size)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int cnt_of(int b);
        return int'(buf_cnt[b*CW +: CW]);
    endfunction

    task automatic cfg(bit dir_in, int typ, int size);
        @(negedge clk);
        cfg_we = 1; cfg_dir_in = dir_in; cfg_type = 2'(typ); cfg_size = CW'(size);
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic hready(bit sel, int cnt);
        @(negedge clk);
        rdy_we = 1; rdy_sel = sel; rdy_cnt = CW'(cnt);
        @(negedge clk);
        rdy_we = 0;
    endtask

    // request; response fields are sampled in the cycle after the request edge
    task automatic req(output int vld, output int code, output int b, output int tx);
        @(negedge clk);
        eng_req = 1;
        @(negedge clk);
        eng_req = 0;
        vld = eng_rsp_vld; code = eng_rsp; b = eng_buf; tx = eng_tx_cnt;
    endtask

    task automatic done(bit ok, int len);
        @(negedge clk);
        eng_done = 1; eng_ok = ok; eng_len = CW'(len);
        @(negedge clk);
        eng_done = 0; eng_ok = 0;
    endtask

    task automatic t_reset;
        chk("R1 rdy", buf_rdy, 0);
        chk("R1 cnt", buf_cnt, 0);
        chk("R1 next", ep_next, 0);
        chk("R1 size", ep_size, 0);
        chk("R1 rsp_vld", eng_rsp_vld, 0);
    endtask

    task automatic t_clamp;
        cfg(0, 0, 600);  chk("R2 bulk clamp", ep_size, 512);
        cfg(0, 1, 100);  chk("R2 intr clamp", ep_size, 64);
        cfg(0, 2, 2000); chk("R2 iso clamp", ep_size, 1024);
        cfg(0, 2, 700);  chk("R2 iso pass", ep_size, 700);
        cfg(0, 3, 600);  chk("R2 rsvd as bulk", ep_size, 512);
        cfg(0, 1, 40);   chk("R2 intr pass", ep_size, 40);
    endtask

    task automatic t_out_bulk;
        int v, c, b, t;
        cfg(0, 0, 512);
        hready(0, 77); hready(1, 77);
        chk("R4 out rdy", buf_rdy, 3);
        chk("R4 out cnt zero", cnt_of(0), 0);
        req(v, c, b, t);
        chk("R5 grant vld", v, 1); chk("R5 grant code", c, 1);
        chk("R5 grant buf", b, 0); chk("R5 out tx cnt", t, 0);
        done(1, 100);
        chk("R7 rdy cleared", buf_rdy, 2);
        chk("R7 out cnt", cnt_of(0), 100);
        chk("R9 next 1", ep_next, 1);
        req(v, c, b, t);
        chk("R9 second buf", b, 1); chk("R9 second code", c, 1);
        done(1, 600);
        chk("R7 out len clamp", cnt_of(1), 512);
        chk("R9 next back 0", ep_next, 0);
        req(v, c, b, t);
        chk("R6 nak vld", v, 1); chk("R6 nak code", c, 2);
        chk("R6 nak rdy kept", buf_rdy, 0);
        chk("R6 nak next kept", ep_next, 0);
        chk("R6 nak cnt kept", cnt_of(0), 100);
    endtask

    task automatic t_fail_retry;
        int v, c, b, t;
        cfg(0, 1, 64);
        hready(0, 0);
        req(v, c, b, t);
        chk("R5 grant intr", c, 1);
        done(0, 10);
        chk("R8 rdy kept", buf_rdy, 1);
        chk("R8 next kept", ep_next, 0);
        req(v, c, b, t);
        chk("R8 retry same buf", b, 0); chk("R8 retry grant", c, 1);
        done(1, 10);
        chk("R8 then ok cnt", cnt_of(0), 10);
        req(v, c, b, t);
        chk("R6 intr nak", c, 2);
    endtask

    task automatic t_in_iso;
        int v, c, b, t;
        cfg(1, 2, 200);
        hready(0, 300);
        chk("R4 in cnt clamp", cnt_of(0), 200);
        hready(1, 50);
        chk("R4 in cnt", cnt_of(1), 50);
        req(v, c, b, t);
        chk("R5 in tx cnt", t, 200);
        done(1, 999);
        chk("R7 in cnt kept", cnt_of(0), 200);
        chk("R7 in rdy cleared", buf_rdy, 2);
        req(v, c, b, t);
        chk("R9 in buf1", b, 1); chk("R5 in tx cnt1", t, 50);
        done(1, 0);
        req(v, c, b, t);
        chk("R6 iso drop vld", v, 1); chk("R6 iso drop code", c, 3);
        chk("R6 iso drop buf", b, 0);
    endtask

    task automatic t_busy_ignore;
        int v, c, b, t;
        cfg(1, 0, 512);
        hready(0, 30);
        req(v, c, b, t);
        chk("R10 first grant", c, 1);
        req(v, c, b, t);
        chk("R10 busy no rsp", v, 0);
        hready(0, 99);
        chk("R10 granted buf write ignored", cnt_of(0), 30);
        done(1, 0);
        chk("R10 next after", ep_next, 1);
        done(1, 0);
        chk("R10 stray done next", ep_next, 1);
        chk("R10 stray done rdy", buf_rdy, 0);
        hready(1, 5);
        req(v, c, b, t);
        chk("R10 grant buf1", b, 1);
        cfg(1, 0, 512);
        chk("R3 cfg clears rdy", buf_rdy, 0);
        chk("R3 cfg clears cnt", buf_cnt, 0);
        chk("R3 cfg next 0", ep_next, 0);
        req(v, c, b, t);
        chk("R3 abandon grant", c, 2);
        // configuration wins over a simultaneous ready write
        @(negedge clk);
        cfg_we = 1; cfg_dir_in = 0; cfg_type = 0; cfg_size = 100;
        rdy_we = 1; rdy_sel = 0;
        @(negedge clk);
        cfg_we = 0; rdy_we = 0;
        chk("R3 cfg priority", buf_rdy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_clamp();
        t_out_bulk();
        t_fail_retry();
        t_in_iso();
        t_busy_ignore();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule